// File: doc/BRIEF.md
# Register file with use-bit hazard interlock

This block is the operand store of a short in-order pipeline. It keeps thirty-two integer registers and gives the decode stage two combinational read ports, while the write-back stage has one write port. Each register has a use bit that marks a result still in flight. Register zero is hard-wired to zero and is never reserved.

The decode stage presents the register numbers of the instruction it holds: a source count, two source indices and an optional destination. The interlock compares these numbers against the use bits. A source whose bit is set is a read-after-write hazard, and a destination whose bit is set is a write-after-write hazard. While either kind of hazard exists, the instruction is held and checked again on the next cycle. When the instruction issues, its destination is reserved. A result arriving at write-back releases its reservation and is readable in the same cycle. That same-cycle release can also lift a hold.

When the pipeline is redirected, a flush input carries a mask of the registers reserved by the squashed instructions. Those use bits are cleared, and no instruction issues in the flush cycle.

Top module: `rfil_regfile`

## Requirements
- R1: After reset every register reads as zero and no use bit is set. A reset in mid-run returns the block to this state.
- R2: Register 0 always reads as zero, and a write-back to it is ignored. An issuing instruction whose destination is register 0 reserves nothing, so such an instruction never raises a WAW hazard.
- R3: A write-back with `wb_valid_i` high stores `wb_data_i` into register `wb_idx_i`, and both read ports return stored values independently.
- R4: A read of the register being written back in the same cycle returns the new value (write-first bypass).
- R5: An instruction that issues with `dst_wr_i` high sets the use bit of `dst_idx_i` at the next clock edge.
- R6: `raw1_o` is high when `src_cnt_i` is at least 1 and the use bit of `src1_idx_i` is set. `raw2_o` is high when `src_cnt_i` is at least 2 and the use bit of `src2_idx_i` is set. A source that the count does not cover never flags a hazard.
- R7: `waw_o` is high when a valid instruction has `dst_wr_i` high and the use bit of `dst_idx_i` is already set.
- R8: `hold_o` is high when any hazard is flagged, and `issue_o` then stays low. `held_o` is high in the cycle after a hold that was not flushed. The instruction issues in the first cycle without a hazard.
- R9: A write-back clears the use bit of its register. The hazard checks made in that same cycle already see the bit as clear.
- R10: With `flush_i` high, every use bit selected by `flush_mask_i` (bit n selects register n) is cleared, and `issue_o` is low in that cycle.
- R11: An instruction with `src_cnt_i` = 0 receives 0 on both operands. One with `src_cnt_i` = 1 receives 0 on `op2_o`. A count of 2 or 3 means two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Decode holds a valid instruction |
| src_cnt_i | input | 2 | Number of register sources (0, 1, 2 or more) |
| src1_idx_i | input | 5 | First source register |
| src2_idx_i | input | 5 | Second source register |
| dst_wr_i | input | 1 | Instruction writes a destination register |
| dst_idx_i | input | 5 | Destination register |
| wb_valid_i | input | 1 | Write-back result present |
| wb_idx_i | input | 5 | Write-back register |
| wb_data_i | input | 32 | Write-back value |
| flush_i | input | 1 | Squash in-flight reservations |
| flush_mask_i | input | 32 | Use bits to clear on flush |
| issue_o | output | 1 | Instruction issues this cycle |
| hold_o | output | 1 | Instruction is held this cycle |
| held_o | output | 1 | Previous cycle ended in a hold |
| raw1_o | output | 1 | RAW hazard on first source |
| raw2_o | output | 1 | RAW hazard on second source |
| waw_o | output | 1 | WAW hazard on destination |
| op1_o | output | 32 | First operand value |
| op2_o | output | 32 | Second operand value |

## Verification
A write-back and a decode check can fall in the same cycle on the same register. A waiting reader is then released, and it receives the new value through the bypass. A waiting writer is released and reserves the register again at once. The bench provokes both cases: it stalls an instruction on a busy register and then applies the matching write-back. It judges the result on `issue_o`, on the hazard flags and on the operand values in that cycle, and on a RAW flag that reappears afterwards. A flush that lands in the same cycle as a held instruction is also covered. The checks cover the cleared use bits, the suppressed issue and the `held_o` value that follows.

// File: rtl/rfil_pkg.sv
`timescale 1ns/1ps
package rfil_pkg;

    // Encoding of the source count presented by decode
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_TWO  = 2'd2,
        SRC_TWOX = 2'd3
    } src_cnt_e;

    // Hazard flags of one decode check
    typedef struct packed {
        logic raw1;
        logic raw2;
        logic waw;
    } hazard_t;

    localparam int unsigned RD_PORTS = 2;

endpackage

// File: rtl/rfil_storage.sv
`timescale 1ns/1ps
module rfil_storage #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDXW  = $clog2(NREGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [IDXW-1:0]                    wr_idx_i,
    input  logic [XLEN-1:0]                    wr_data_i,
    input  logic [rfil_pkg::RD_PORTS-1:0][IDXW-1:0] rd_idx_i,
    output logic [rfil_pkg::RD_PORTS-1:0][XLEN-1:0] rd_data_o
);

    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] regs;
    } store_t;

    store_t st_d, st_q;
    logic   wr_live;

    // a write to register zero is dropped
    assign wr_live = wr_en_i && (wr_idx_i != '0);

    always_comb begin
        st_d = st_q;
        if (wr_live) begin
            st_d.regs[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read ports with write-first bypass
    for (genvar p = 0; p < rfil_pkg::RD_PORTS; p++) begin : g_rd
        always_comb begin
            if (rd_idx_i[p] == '0) begin
                rd_data_o[p] = '0;
            end else if (wr_live && (wr_idx_i == rd_idx_i[p])) begin
                rd_data_o[p] = wr_data_i;
            end else begin
                rd_data_o[p] = st_q.regs[rd_idx_i[p]];
            end
        end

        // R2
        zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx_i[p] == '0) |-> (rd_data_o[p] == '0));

        // R3
        stored_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_live && (rd_idx_i[p] == wr_idx_i))
            |=> ((rd_idx_i[p] != $past(wr_idx_i)) || (wr_en_i && (wr_idx_i == rd_idx_i[p]))
                 || (rd_data_o[p] == $past(wr_data_i))));
    end

endmodule

// File: rtl/rfil_busy.sv
`timescale 1ns/1ps
module rfil_busy #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned IDXW  = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en_i,
    input  logic [IDXW-1:0]  clr_idx_i,
    input  logic             set_en_i,
    input  logic [IDXW-1:0]  set_idx_i,
    input  logic             flush_en_i,
    input  logic [NREGS-1:0] flush_mask_i,
    output logic [NREGS-1:0] busy_eff_o
);

    localparam logic [NREGS-1:0] ONE = {{(NREGS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NREGS-1:0] busy;
    } busy_st_t;

    busy_st_t st_d, st_q;
    logic [NREGS-1:0] clr_vec, set_vec, fl_vec;

    always_comb begin
        clr_vec = clr_en_i   ? (ONE << clr_idx_i) : '0;
        set_vec = (set_en_i && (set_idx_i != '0)) ? (ONE << set_idx_i) : '0;
        fl_vec  = flush_en_i ? flush_mask_i : '0;
    end

    // use bits as the hazard check sees them: write-back release applied
    assign busy_eff_o = st_q.busy & ~clr_vec;

    always_comb begin
        st_d      = st_q;
        st_d.busy = ((st_q.busy & ~clr_vec) & ~fl_vec) | set_vec;
        st_d.busy[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    zero_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy[0]);

    // R5
    set_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i && (set_idx_i != '0)) |=> st_q.busy[$past(set_idx_i)]);

    // R9
    clear_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !(set_en_i && (set_idx_i == clr_idx_i))) |=> !st_q.busy[$past(clr_idx_i)]);

    // R10
    flush_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en_i && !set_en_i) |=> ((st_q.busy & $past(flush_mask_i)) == '0));

endmodule

// File: rtl/rfil_interlock.sv
`timescale 1ns/1ps
module rfil_interlock #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned IDXW  = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       src_cnt_i,
    input  logic [IDXW-1:0]  src1_idx_i,
    input  logic [IDXW-1:0]  src2_idx_i,
    input  logic             dst_wr_i,
    input  logic [IDXW-1:0]  dst_idx_i,
    input  logic             flush_i,
    input  logic [NREGS-1:0] busy_eff_i,
    output rfil_pkg::hazard_t haz_o,
    output logic             hold_o,
    output logic             issue_o,
    output logic             set_en_o,
    output logic [IDXW-1:0]  set_idx_o,
    output logic             use1_o,
    output logic             use2_o
);

    import rfil_pkg::*;

    src_cnt_e cnt;
    logic     dst_live;

    always_comb begin
        cnt      = src_cnt_e'(src_cnt_i);
        use1_o   = (cnt != SRC_NONE);
        use2_o   = (cnt == SRC_TWO) || (cnt == SRC_TWOX);
        dst_live = dst_wr_i && (dst_idx_i != '0);

        haz_o.raw1 = valid_i && use1_o && (src1_idx_i != '0) && busy_eff_i[src1_idx_i];
        haz_o.raw2 = valid_i && use2_o && (src2_idx_i != '0) && busy_eff_i[src2_idx_i];
        haz_o.waw  = valid_i && dst_live && busy_eff_i[dst_idx_i];

        hold_o    = haz_o.raw1 || haz_o.raw2 || haz_o.waw;
        issue_o   = valid_i && !hold_o && !flush_i;
        set_en_o  = issue_o && dst_live;
        set_idx_o = dst_idx_i;
    end

    // R8
    issue_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_o && hold_o));

    // R10
    flush_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !issue_o);

    // R6
    uncounted_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_cnt_i == 2'd0) |-> !(haz_o.raw1 || haz_o.raw2));

endmodule

// File: rtl/rfil_regfile.sv
`timescale 1ns/1ps
module rfil_regfile #(
    parameter int unsigned NREGS = 32,
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDXW  = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid_i,
    input  logic [1:0]       src_cnt_i,
    input  logic [IDXW-1:0]  src1_idx_i,
    input  logic [IDXW-1:0]  src2_idx_i,
    input  logic             dst_wr_i,
    input  logic [IDXW-1:0]  dst_idx_i,
    input  logic             wb_valid_i,
    input  logic [IDXW-1:0]  wb_idx_i,
    input  logic [XLEN-1:0]  wb_data_i,
    input  logic             flush_i,
    input  logic [NREGS-1:0] flush_mask_i,
    output logic             issue_o,
    output logic             hold_o,
    output logic             held_o,
    output logic             raw1_o,
    output logic             raw2_o,
    output logic             waw_o,
    output logic [XLEN-1:0]  op1_o,
    output logic [XLEN-1:0]  op2_o
);

    import rfil_pkg::*;

    typedef struct packed {
        logic held;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NREGS-1:0]                  busy_eff;
    hazard_t                           haz;
    logic                              set_en;
    logic [IDXW-1:0]                   set_idx;
    logic                              use1, use2;
    logic [RD_PORTS-1:0][IDXW-1:0]     rd_idx;
    logic [RD_PORTS-1:0][XLEN-1:0]     rd_data;

    assign rd_idx[0] = src1_idx_i;
    assign rd_idx[1] = src2_idx_i;

    rfil_storage #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wb_valid_i),
        .wr_idx_i  (wb_idx_i),
        .wr_data_i (wb_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    rfil_busy #(.NREGS(NREGS), .IDXW(IDXW)) u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_en_i     (wb_valid_i),
        .clr_idx_i    (wb_idx_i),
        .set_en_i     (set_en),
        .set_idx_i    (set_idx),
        .flush_en_i   (flush_i),
        .flush_mask_i (flush_mask_i),
        .busy_eff_o   (busy_eff)
    );

    rfil_interlock #(.NREGS(NREGS), .IDXW(IDXW)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (issue_valid_i),
        .src_cnt_i  (src_cnt_i),
        .src1_idx_i (src1_idx_i),
        .src2_idx_i (src2_idx_i),
        .dst_wr_i   (dst_wr_i),
        .dst_idx_i  (dst_idx_i),
        .flush_i    (flush_i),
        .busy_eff_i (busy_eff),
        .haz_o      (haz),
        .hold_o     (hold_o),
        .issue_o    (issue_o),
        .set_en_o   (set_en),
        .set_idx_o  (set_idx),
        .use1_o     (use1),
        .use2_o     (use2)
    );

    // operands: sources beyond the count forward zero
    always_comb begin
        op1_o  = use1 ? rd_data[0] : '0;
        op2_o  = use2 ? rd_data[1] : '0;
        raw1_o = haz.raw1;
        raw2_o = haz.raw2;
        waw_o  = haz.waw;
    end

    // held decode state: set by an unflushed hold
    always_comb begin
        st_d      = st_q;
        st_d.held = hold_o && !flush_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;

    // R8
    hold_then_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !flush_i) |=> held_o);

    // R10
    flush_drops_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !held_o);

    // R11
    no_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_cnt_i == 2'd0) |-> ((op1_o == '0) && (op2_o == '0)));

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_i && (wb_idx_i != '0) && (src_cnt_i != 2'd0) && (src1_idx_i == wb_idx_i))
        |-> (op1_o == wb_data_i));

endmodule

// File: tb/rfil_regfile_test.sv
`timescale 1ns/1ps
module rfil_regfile_test;

    localparam int NREGS = 32;
    localparam int XLEN  = 32;
    localparam int IDXW  = 5;
    localparam int NV    = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             issue_valid;
    logic [1:0]       src_cnt;
    logic [IDXW-1:0]  src1, src2, dst;
    logic             dst_wr;
    logic             wb_valid;
    logic [IDXW-1:0]  wb_idx;
    logic [XLEN-1:0]  wb_data;
    logic             flush;
    logic [NREGS-1:0] flush_mask;
    logic             issue, hold, held, raw1, raw2, waw;
    logic [XLEN-1:0]  op1, op2;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rfil_regfile #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid_i(issue_valid), .src_cnt_i(src_cnt),
        .src1_idx_i(src1), .src2_idx_i(src2),
        .dst_wr_i(dst_wr), .dst_idx_i(dst),
        .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_data_i(wb_data),
        .flush_i(flush), .flush_mask_i(flush_mask),
        .issue_o(issue), .hold_o(hold), .held_o(held),
        .raw1_o(raw1), .raw2_o(raw2), .waw_o(waw),
        .op1_o(op1), .op2_o(op2)
    );

    typedef struct packed {
        logic            wbv;
        logic [4:0]      wbi;
        logic [31:0]     wbd;
        logic            iv;
        logic [1:0]      sc;
        logic [4:0]      s1;
        logic [4:0]      s2;
        logic            dw;
        logic [4:0]      d;
        logic            fl;
        logic [31:0]     fm;
        logic            e_iss;
        logic            e_hold;
        logic            e_r1;
        logic            e_r2;
        logic            e_waw;
        logic            e_held;
        logic [31:0]     e_op1;
        logic [31:0]     e_op2;
    } vec_t;

    // Each row is one cycle. Tags: R3 stores, R4 bypass, R5 reservation,
    // R6 RAW, R7 WAW, R8 hold/held, R9 same-cycle release, R10 flush,
    // R11 unused operands, R2 register zero.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd3, 32'h11, 1'b0, 2'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0},
        '{1'b1, 5'd4, 32'h22, 1'b1, 2'd2, 5'd3, 5'd4, 1'b1, 5'd5, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h11, 32'h22},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd1, 5'd5, 5'd3, 1'b1, 5'd6, 1'b0, 32'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd1, 5'd5, 5'd3, 1'b1, 5'd6, 1'b0, 32'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 32'h0, 32'h0},
        '{1'b1, 5'd5, 32'h55, 1'b1, 2'd1, 5'd5, 5'd3, 1'b1, 5'd6, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h55, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd2, 5'd3, 5'd6, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h11, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd1, 5'd3, 5'd6, 1'b1, 5'd6, 1'b0, 32'h0, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 32'h11, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd0, 5'd6, 5'd6, 1'b1, 5'd7, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd2, 5'd6, 5'd7, 1'b0, 5'd0, 1'b1, 32'h40, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 32'h0, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd2, 5'd6, 5'd7, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0, 32'h0},
        '{1'b1, 5'd0, 32'h99, 1'b1, 2'd2, 5'd0, 5'd3, 1'b1, 5'd0, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h11},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd1, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0, 32'h0},
        '{1'b1, 5'd7, 32'h77, 1'b1, 2'd2, 5'd7, 5'd7, 1'b1, 5'd7, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h77, 32'h77},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd1, 5'd7, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 32'h77, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b0, 2'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 32'hFFFFFFFF, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0, 32'h0},
        '{1'b0, 5'd0, 32'h0,  1'b1, 2'd2, 5'd7, 5'd5, 1'b1, 5'd7, 1'b0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 32'h77, 32'h55}
    };

    task automatic chk(input string tag, input int idx, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual=%0h expected=%0h", tag, idx, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_valid = 1'b0; src_cnt = 2'd0; src1 = '0; src2 = '0;
        dst_wr = 1'b0; dst = '0; wb_valid = 1'b0; wb_idx = '0; wb_data = '0;
        flush = 1'b0; flush_mask = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();

        // R1: reset state, every register zero and no reservations
        #5;
        chk("R1 held after reset", -1, {31'b0, held}, 32'h0);
        for (int k = 0; k < NREGS / 2; k++) begin
            @(negedge clk);
            issue_valid = 1'b1; src_cnt = 2'd2;
            src1 = IDXW'(2 * k); src2 = IDXW'(2 * k + 1);
            dst_wr = 1'b0;
            #5;
            chk("R1 op1 reset value", k, op1, 32'h0);
            chk("R1 op2 reset value", k, op2, 32'h0);
            chk("R1 no hazard after reset", k, {29'b0, raw1, raw2, hold}, 32'h0);
        end

        // vector walk: inputs at the falling edge, outputs read 5 ns later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wb_valid = VECS[i].wbv; wb_idx = VECS[i].wbi; wb_data = VECS[i].wbd;
            issue_valid = VECS[i].iv; src_cnt = VECS[i].sc;
            src1 = VECS[i].s1; src2 = VECS[i].s2;
            dst_wr = VECS[i].dw; dst = VECS[i].d;
            flush = VECS[i].fl; flush_mask = VECS[i].fm;
            #5;
            chk("R8 issue", i, {31'b0, issue}, {31'b0, VECS[i].e_iss});
            chk("R8 hold", i, {31'b0, hold}, {31'b0, VECS[i].e_hold});
            chk("R6 raw1", i, {31'b0, raw1}, {31'b0, VECS[i].e_r1});
            chk("R6 raw2", i, {31'b0, raw2}, {31'b0, VECS[i].e_r2});
            chk("R7 waw", i, {31'b0, waw}, {31'b0, VECS[i].e_waw});
            chk("R8 held", i, {31'b0, held}, {31'b0, VECS[i].e_held});
            chk("R3 R4 R11 op1", i, op1, VECS[i].e_op1);
            chk("R3 R4 R11 op2", i, op2, VECS[i].e_op2);
        end

        // R5 R9: reservation made in the last step is still pending
        @(negedge clk);
        idle_inputs();
        issue_valid = 1'b1; src_cnt = 2'd3; src1 = 5'd4; src2 = 5'd7;
        #5;
        chk("R5 raw2 on reserved r7", 100, {31'b0, raw2}, 32'h1);
        chk("R11 count 3 reads two sources", 100, op1, 32'h22);

        // R2: destination zero never reserves, r0 stays zero after a write
        @(negedge clk);
        idle_inputs();
        issue_valid = 1'b1; src_cnt = 2'd1; src1 = 5'd0; dst_wr = 1'b1; dst = 5'd0;
        #5;
        chk("R2 no waw on r0", 101, {31'b0, waw}, 32'h0);
        chk("R2 r0 reads zero", 101, op1, 32'h0);

        // R1: mid-run reset clears data and reservations
        do_reset();
        issue_valid = 1'b1; src_cnt = 2'd2; src1 = 5'd3; src2 = 5'd7;
        dst_wr = 1'b1; dst = 5'd7;
        #5;
        chk("R1 r3 cleared by reset", 102, op1, 32'h0);
        chk("R1 r7 cleared by reset", 102, op2, 32'h0);
        chk("R1 reservation cleared", 102, {29'b0, raw2, waw, issue}, 32'h1);

        @(negedge clk);
        idle_inputs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule